// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a serial-input digital-to-analog converter. A host drives a three-wire serial link: an active-low frame select, a serial clock and a data line. The block brings those three wires into its own system clock domain through two-flop synchronizers and detects the serial clock edges there. It shifts one data bit in on each falling serial clock edge while the frame select is low, and decodes the command when the last bit of the frame arrives.

A two-bit opcode heads every frame. One opcode loads a new converter code and pulses an update strobe in the same action. One sets a two-bit power-down mode. One does nothing, and the fourth is reserved and ignored. A parameter picks the narrow frame (16 bits carrying a 14-bit code) or the wide frame (24 bits carrying a 16-bit code and six trailing bits that are not used). The block drives the held code, the power-down mode and the one-cycle update strobe. The analog path lies outside it.

Top module: `spi_dac_rx`

## Requirements
- R1: During and after reset, `dac_code` is zero, `pd_mode` is zero and `dac_update` is low.
- R2: While `spi_cs_n` is low, one bit of `spi_din` is taken on each falling edge of `spi_sclk`, most significant bit first. A frame starts when `spi_cs_n` goes low. In the narrow frame, bits [15:14] are the opcode and bits [13:0] are the code.
- R3: Opcode 2'b01 (write-through) loads the code field into `dac_code` and raises `dac_update` for exactly one system clock cycle.
- R4: Opcode 2'b10 (power-down) loads `pd_mode` from frame bits [12:11] in the narrow frame and [20:19] in the wide frame. Bit [13] or [21] is not used. `dac_code` stays unchanged and no update pulse is raised.
- R5: Opcode 2'b00 changes neither `dac_code` nor `pd_mode` and raises no update pulse.
- R6: Opcode 2'b11 is reserved. It changes neither register and raises no update pulse.
- R7: If `spi_cs_n` rises before the last bit of a frame, the bits taken so far are discarded, and the next frame starts again from bit zero.
- R8: Falling serial clock edges after the last bit of a frame, while `spi_cs_n` stays low, have no effect until `spi_cs_n` has gone high again.
- R9: The command takes effect on the falling edge that carries the last bit. The update pulse comes while `spi_cs_n` is still low, and no rising edge of `spi_cs_n` is needed.
- R10: Frames are received correctly whether `spi_sclk` rests high or low while `spi_cs_n` is high.
- R11: In the wide frame (WIDE_FRAME=1), bits [23:22] are the opcode, bits [21:6] are the 16-bit code, and bits [5:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, asynchronous to clk |
| spi_cs_n | input | 1 | Active-low frame select, asynchronous |
| spi_din | input | 1 | Serial data, MSB first |
| dac_code | output | CODE_W (14 or 16) | Held converter code |
| pd_mode | output | 2 | Held power-down mode, 0 = normal operation |
| dac_update | output | 1 | One-cycle strobe when a write-through completes |

## Verification
The hardest case to reach is a frame that ends inside the select window and is followed by more clock edges, or one that is cut short by an early select rise. Only a count that is exactly right separates these from a valid frame. The stimulus tasks therefore take a bit count and a number of extra edges, so frames can be truncated, padded and sent with either clock idle level. A behavioural model in the bench replays the synchronizer delay from a short history of sampled pins, decodes each frame by shifting and masking, and checks both frame widths against the design on every clock.

// File: rtl/spi_dac_rx_pkg.sv
package spi_dac_rx_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_WRITE = 2'b01,
    OP_PDOWN = 2'b10,
    OP_RSVD  = 2'b11
  } dac_op_e;

  function automatic int frame_bits(input bit wide);
    return wide ? 24 : 16;
  endfunction

  function automatic int code_bits(input bit wide);
    return wide ? 16 : 14;
  endfunction

endpackage

// File: rtl/spi_dac_sync.sv
module spi_dac_sync #(
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end
    assign sync_out[g] = stab_q;
  end

endmodule

// File: rtl/spi_dac_shifter.sv
module spi_dac_shifter #(
  parameter int FL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_sclk,
  input  logic          s_cs_n,
  input  logic          s_din,
  output logic          frame_vld,
  output logic [FL-1:0] frame
);

  localparam int CNT_W = $clog2(FL + 1);

  logic             sclk_q;
  logic [CNT_W-1:0] bit_cnt;
  logic             frame_full;
  logic [FL-2:0]    shreg;

  wire sclk_fall = sclk_q & ~s_sclk;
  wire take_bit  = ~s_cs_n & sclk_fall & ~frame_full;
  wire last_bit  = take_bit && (bit_cnt == CNT_W'(FL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      bit_cnt    <= '0;
      frame_full <= 1'b0;
      shreg      <= '0;
      frame_vld  <= 1'b0;
      frame      <= '0;
    end else begin
      sclk_q    <= s_sclk;
      frame_vld <= 1'b0;
      if (s_cs_n) begin
        bit_cnt    <= '0;
        frame_full <= 1'b0;
      end else if (take_bit) begin
        shreg   <= {shreg[FL-3:0], s_din};
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          frame_full <= 1'b1;
          frame_vld  <= 1'b1;
          frame      <= {shreg, s_din};
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FL)); // R8
  AST_CS_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |=> (bit_cnt == '0 && !frame_full)); // R7
  AST_VLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> $past(!s_cs_n)); // R9
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld); // R8

endmodule

// File: rtl/spi_dac_decode.sv
module spi_dac_decode
  import spi_dac_rx_pkg::*;
#(
  parameter int FL = 16,
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_vld,
  input  logic [FL-1:0] frame,
  output logic [CW-1:0] dac_code,
  output logic [1:0]    pd_mode,
  output logic          dac_update
);

  function automatic dac_op_e op_field(input logic [FL-1:0] f);
    return dac_op_e'(f[FL-1 -: 2]);
  endfunction

  function automatic logic [CW-1:0] code_field(input logic [FL-1:0] f);
    return f[FL-3 -: CW];
  endfunction

  function automatic logic [1:0] mode_field(input logic [FL-1:0] f);
    return f[FL-4 -: 2];
  endfunction

  dac_op_e op;
  assign op = op_field(frame);

  wire is_write = frame_vld && (op == OP_WRITE);
  wire is_pdown = frame_vld && (op == OP_PDOWN);
  wire is_rsvd  = frame_vld && (op == OP_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code   <= '0;
      pd_mode    <= 2'b00;
      dac_update <= 1'b0;
    end else begin
      dac_update <= is_write;
      if (is_write) dac_code <= code_field(frame);
      if (is_pdown) pd_mode  <= mode_field(frame);
    end
  end

  AST_UPD_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |-> $past(frame_vld)); // R3
  AST_HOLD_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> ($stable(dac_code) && $stable(pd_mode))); // R5
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    is_rsvd |=> ($stable(dac_code) && $stable(pd_mode) && !dac_update)); // R6
  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    is_pdown |=> ($stable(dac_code) && !dac_update)); // R4

endmodule

// File: rtl/spi_dac_rx.sv
module spi_dac_rx
  import spi_dac_rx_pkg::*;
#(
  parameter bit WIDE_FRAME = 1'b0,
  localparam int FL     = frame_bits(WIDE_FRAME),
  localparam int CODE_W = code_bits(WIDE_FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_din,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic              dac_update
);

  logic [2:0]    pins_sync;
  logic          frame_vld;
  logic [FL-1:0] frame;

  spi_dac_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_din, spi_cs_n, spi_sclk}),
    .sync_out (pins_sync)
  );

  spi_dac_shifter #(.FL(FL)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_sclk    (pins_sync[0]),
    .s_cs_n    (pins_sync[1]),
    .s_din     (pins_sync[2]),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  spi_dac_decode #(.FL(FL), .CW(CODE_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .frame      (frame),
    .dac_code   (dac_code),
    .pd_mode    (pd_mode),
    .dac_update (dac_update)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (dac_code == '0 && pd_mode == 2'b00 && !dac_update)); // R1

endmodule

// File: tb/test_spi_dac_rx.sv
module test_spi_dac_rx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic cs_n_a = 1'b1;
  logic cs_n_b = 1'b1;

  logic [13:0] code_a;
  logic [15:0] code_b;
  logic [1:0]  pd_a, pd_b;
  logic        upd_a, upd_b;

  always #2 clk = ~clk;

  spi_dac_rx i_spi_dac_rx (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n_a), .spi_din(din),
    .dac_code(code_a), .pd_mode(pd_a), .dac_update(upd_a));

  spi_dac_rx #(.WIDE_FRAME(1'b1)) i_spi_dac_rx_wide (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n_b), .spi_din(din),
    .dac_code(code_b), .pd_mode(pd_b), .dac_update(upd_b));

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: history of sampled pins, frame accumulated by shifting
  logic h_sclk [4];
  logic h_din  [4];
  logic h_cs   [2][4];
  int   m_cnt  [2];
  bit   m_full [2];
  logic [23:0] m_sh [2];
  bit   m_pend [2];
  logic [23:0] m_frame [2];
  int   exp_code [2];
  int   exp_pd   [2];
  bit   exp_upd  [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_sclk[i] = 1'b0; h_din[i] = 1'b0; h_cs[0][i] = 1'b1; h_cs[1][i] = 1'b1;
      end
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_full[k] = 0; m_sh[k] = '0; m_pend[k] = 0; m_frame[k] = '0;
        exp_code[k] = 0; exp_pd[k] = 0; exp_upd[k] = 0;
      end
    end else begin
      for (int i = 3; i > 0; i--) begin
        h_sclk[i] = h_sclk[i-1]; h_din[i] = h_din[i-1];
        h_cs[0][i] = h_cs[0][i-1]; h_cs[1][i] = h_cs[1][i-1];
      end
      h_sclk[0] = sclk; h_din[0] = din; h_cs[0][0] = cs_n_a; h_cs[1][0] = cs_n_b;
      for (int k = 0; k < 2; k++) begin
        int fl, cw, op;
        fl = (k == 0) ? 16 : 24;
        cw = (k == 0) ? 14 : 16;
        exp_upd[k] = 0;
        if (m_pend[k]) begin
          m_pend[k] = 0;
          op = int'((m_frame[k] >> (fl - 2)) & 24'h3);
          if (op == 1) begin
            exp_code[k] = int'((m_frame[k] >> (fl - 2 - cw)) & ((24'h1 << cw) - 1));
            exp_upd[k] = 1;
          end else if (op == 2) begin
            exp_pd[k] = int'((m_frame[k] >> (fl - 5)) & 24'h3);
          end
        end
        if (h_cs[k][2]) begin
          m_cnt[k] = 0; m_full[k] = 0;
        end else if (h_sclk[3] && !h_sclk[2] && !m_full[k]) begin
          m_sh[k] = (m_sh[k] << 1) | {23'd0, h_din[2]};
          m_cnt[k]++;
          if (m_cnt[k] == fl) begin
            m_full[k] = 1; m_pend[k] = 1; m_frame[k] = m_sh[k];
          end
        end
      end
    end
  end

  int  upd_count_a = 0;
  bit  upd_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_a) upd_count_a++;
      if (upd_a || upd_b) upd_seen = 1;
      check(int'(code_a) == exp_code[0], {cur_req, " narrow code"}, int'(code_a), exp_code[0]);
      check(int'(pd_a) == exp_pd[0], {cur_req, " narrow mode"}, int'(pd_a), exp_pd[0]);
      check(upd_a == exp_upd[0], {cur_req, " narrow strobe"}, int'(upd_a), int'(exp_upd[0]));
      check(int'(code_b) == exp_code[1], {cur_req, " wide code"}, int'(code_b), exp_code[1]);
      check(int'(pd_b) == exp_pd[1], {cur_req, " wide mode"}, int'(pd_b), exp_pd[1]);
      check(upd_b == exp_upd[1], {cur_req, " wide strobe"}, int'(upd_b), int'(exp_upd[1]));
    end
  end

  task automatic clock_bit(input logic b, input bit idle_high);
    din = b;
    if (!idle_high) begin sclk = 1'b1; repeat (3) @(negedge clk); end
    sclk = 1'b0; repeat (3) @(negedge clk);
    if (idle_high) begin sclk = 1'b1; repeat (3) @(negedge clk); end
  endtask

  bit seen_early;

  task automatic send_frame(input int k, input logic [23:0] bits, input int nbits,
                            input bit idle_high, input int extra);
    @(negedge clk);
    sclk = idle_high;
    repeat (4) @(negedge clk);
    if (k == 0) cs_n_a = 1'b0; else cs_n_b = 1'b0;
    repeat (3) @(negedge clk);
    upd_seen = 0;
    for (int i = nbits - 1; i >= 0; i--) clock_bit(bits[i], idle_high);
    for (int i = 0; i < extra; i++) clock_bit(1'b1, idle_high);
    repeat (8) @(negedge clk);
    seen_early = upd_seen;
    if (k == 0) cs_n_a = 1'b1; else cs_n_b = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int cnt0;
    repeat (3) @(negedge clk);
    check(code_a == 14'd0 && pd_a == 2'd0 && !upd_a, "R1 reset narrow", int'(code_a), 0);
    check(code_b == 16'd0 && pd_b == 2'd0 && !upd_b, "R1 reset wide", int'(code_b), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(code_a == 14'd0 && pd_a == 2'd0, "R1 after release", int'(code_a), 0);

    cur_req = "R2";
    send_frame(0, 24'h005ABC, 16, 1'b0, 0);
    check(code_a == 14'h1ABC, "R2 R3 write-through code", int'(code_a), 'h1ABC);
    cur_req = "R9";
    check(seen_early, "R9 strobe before select rise", int'(seen_early), 1);

    cur_req = "R4";
    send_frame(0, 24'h009800, 16, 1'b0, 0);
    check(pd_a == 2'd3, "R4 power-down mode", int'(pd_a), 3);
    check(code_a == 14'h1ABC && !seen_early, "R4 code kept, no strobe", int'(code_a), 'h1ABC);

    cur_req = "R5";
    send_frame(0, 24'h003FFF, 16, 1'b0, 0);
    check(code_a == 14'h1ABC && pd_a == 2'd3 && !seen_early, "R5 no-op", int'(code_a), 'h1ABC);

    cur_req = "R6";
    send_frame(0, 24'h00C800, 16, 1'b0, 0);
    check(code_a == 14'h1ABC && pd_a == 2'd3 && !seen_early, "R6 reserved ignored", int'(pd_a), 3);

    cur_req = "R7";
    send_frame(0, 24'h0001FF, 10, 1'b0, 0);
    check(code_a == 14'h1ABC && !seen_early, "R7 partial discarded", int'(code_a), 'h1ABC);
    send_frame(0, 24'h004055, 16, 1'b0, 0);
    check(code_a == 14'h0055, "R7 next frame from bit zero", int'(code_a), 'h0055);

    cur_req = "R8";
    cnt0 = upd_count_a;
    send_frame(0, 24'h006222, 16, 1'b0, 5);
    check(code_a == 14'h2222, "R8 extra edges ignored", int'(code_a), 'h2222);
    check(upd_count_a - cnt0 == 1, "R8 single strobe", upd_count_a - cnt0, 1);

    cur_req = "R10";
    send_frame(0, 24'h007001, 16, 1'b1, 0);
    check(code_a == 14'h3001, "R10 clock idles high", int'(code_a), 'h3001);
    send_frame(0, 24'h004321, 16, 1'b0, 0);
    check(code_a == 14'h0321, "R10 clock idles low", int'(code_a), 'h0321);

    cur_req = "R11";
    send_frame(1, 24'h6FBBEA, 24, 1'b0, 0);
    check(code_b == 16'hBEEF, "R11 wide code", int'(code_b), 'hBEEF);
    check(code_a == 14'h0321, "R11 narrow untouched", int'(code_a), 'h0321);
    send_frame(1, 24'h8FFFFF, 24, 1'b1, 0);
    check(pd_b == 2'd1 && code_b == 16'hBEEF, "R11 R4 wide power-down", int'(pd_b), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule